// File: doc/BRIEF.md
# Serial ADC Word Serializer

This block turns one parallel converter sample per frame into a double-data-rate serial stream. It also produces two timing outputs. The first is a bit-rate data clock that a receiver uses to capture every bit on both of its edges. The second is a frame clock that marks where each word begins. Everything runs from one fast clock at three times the bit rate, so each serial bit lasts three fast cycles. Six fast cycles make one data-clock period, which means a single fast cycle is a 60-degree step of that clock.

Three configuration inputs shape the stream. A word-length select chooses between 12-bit words and a shortened 10-bit word. An order select sends either the most or the least significant bit first. A 3-bit phase code shifts the data clock against the data transitions in 60-degree steps. The block samples the configuration and the parallel sample together at the edge that starts a word, and holds both for the whole frame. The producer can therefore change its inputs at any time without breaking a frame. Code 3 (180 degrees) is the recommended default phase.

Top module: `ser_word_serializer`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `ser_data`, `ser_dclk` and `ser_fclk` are all low in the following cycle. They stay low until the first word starts.
- R2: The first rising edge with `rst` low captures the configuration and `sample_in`. The first bit of that word appears on the outputs one cycle after that edge. Every bit is held for exactly 3 cycles, and the next word follows with no gap.
- R3: With `cfg_lsb_first` = 0, bit k of a frame (k = 0 first) carries `sample_in[11-k]` in both word lengths.
- R4: With `cfg_lsb_first` = 1, bit k carries `sample_in[k]` in 12-bit mode and `sample_in[2+k]` in 10-bit mode.
- R5: With `cfg_short` = 1, a frame holds 10 bits (`sample_in[11:2]`) and lasts 30 cycles. With `cfg_short` = 0, a frame holds 12 bits and lasts 36 cycles.
- R6: `ser_fclk` is high during the first half of the bits of each frame (6 of 12, or 5 of 10) and low during the rest. It rises in the same cycle as the first bit.
- R7: With phase code p (0..5), `ser_dclk` is high in cycle t of a frame (t = 0 for the first cycle) exactly when (t - p) mod 6 is 0, 1 or 2. This gives a 6-cycle period, and each code step delays the clock by 60 degrees.
- R8: Phase codes 6 and 7 behave as codes 0 and 1.
- R9: `cfg_short`, `cfg_lsb_first` and `cfg_phase` are sampled only at the edge that starts a word. Changes made during a frame have no effect on that frame.
- R10: `sample_in` is sampled at the same word-start edge. Later changes do not alter the bits of the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, three cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 12 | Parallel converter sample |
| cfg_short | input | 1 | 1 selects the 10-bit word, 0 the 12-bit word |
| cfg_lsb_first | input | 1 | 1 sends the least significant bit first |
| cfg_phase | input | 3 | Data-clock phase code, 60 degrees per step |
| ser_data | output | 1 | Serial data line |
| ser_dclk | output | 1 | Bit-rate data clock (DDR capture) |
| ser_fclk | output | 1 | Frame clock, high for the first half of each word |

## Verification
Several properties are checked on every cycle: the configuration stays unchanged inside a frame, the captured word stays unchanged inside a frame, the bit counter stays inside the active word length, the frame clock rises only on a frame's first bit, the first bit in MSB-first order is the top bit sampled two edges earlier, and the outputs are quiet after reset. The bench model is what shows the exact bit sequence for each order and length, the data-clock waveform for all eight phase codes, and frame lengths of 30 and 36 cycles. Only its scenarios can show that mid-frame changes to the configuration and sample reach the stream on the next word and not the current one.

// File: rtl/ser_pkg.sv
package ser_pkg;

    // Default word widths and slot geometry.
    localparam int FULL_BITS  = 12;
    localparam int SHORT_BITS = 10;
    localparam int SLOTS      = 3;   // fast cycles per serial bit
    localparam int PH_STEPS   = 6;   // fast cycles per data-clock period
    localparam logic [2:0] DEF_PHASE = 3'd3;  // 180 degrees

    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } len_e;

    typedef struct packed {
        len_e       len;
        logic       lsb_first;
        logic [2:0] phase;
    } ser_cfg_t;

    // Fold codes 6 and 7 onto 0 and 1.
    function automatic logic [2:0] phase_fold(input logic [2:0] code);
        return (code >= 3'(PH_STEPS)) ? code - 3'(PH_STEPS) : code;
    endfunction

endpackage

// File: rtl/ser_slot_timer.sv
module ser_slot_timer
    import ser_pkg::*;
#(
    parameter int FULL_W  = FULL_BITS,
    parameter int SHORT_W = SHORT_BITS,
    localparam int BW     = $clog2(FULL_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  ser_cfg_t      cfg_in,
    output logic          live,
    output logic          wrap,
    output logic [BW-1:0] bidx,
    output logic [1:0]    sub,
    output logic [2:0]    ph6,
    output ser_cfg_t      cfg_q
);

    localparam logic [BW-1:0] LAST_FULL  = BW'(FULL_W - 1);
    localparam logic [BW-1:0] LAST_SHORT = BW'(SHORT_W - 1);
    localparam logic [1:0]    SUB_LAST   = 2'(SLOTS - 1);
    localparam logic [2:0]    PH_LAST    = 3'(PH_STEPS - 1);

    logic [BW-1:0] last_bit;

    always_comb begin
        last_bit = (cfg_q.len == LEN_SHORT) ? LAST_SHORT : LAST_FULL;
        wrap     = !live || (bidx == last_bit && sub == SUB_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live  <= 1'b0;
            bidx  <= '0;
            sub   <= '0;
            ph6   <= '0;
            cfg_q <= '{len: LEN_FULL, lsb_first: 1'b0, phase: DEF_PHASE};
        end else begin
            live <= 1'b1;
            if (wrap) begin
                bidx  <= '0;
                sub   <= '0;
                ph6   <= '0;
                cfg_q <= '{len: cfg_in.len, lsb_first: cfg_in.lsb_first,
                           phase: phase_fold(cfg_in.phase)};
            end else begin
                ph6 <= (ph6 == PH_LAST) ? 3'd0 : ph6 + 3'd1;
                if (sub == SUB_LAST) begin
                    sub  <= '0;
                    bidx <= bidx + 1'b1;
                end else begin
                    sub <= sub + 2'd1;
                end
            end
        end
    end

    // R9: configuration frozen between word boundaries
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cfg_q));

    // R5: bit counter never leaves the active word length
    a_r5_bit_in_word: assert property (@(posedge clk) disable iff (rst)
        live |-> (bidx <= last_bit && sub <= SUB_LAST));

endmodule

// File: rtl/ser_bit_picker.sv
module ser_bit_picker
    import ser_pkg::*;
#(
    parameter int FULL_W  = FULL_BITS,
    parameter int SHORT_W = SHORT_BITS,
    localparam int BW     = $clog2(FULL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              live,
    input  logic              wrap,
    input  logic [FULL_W-1:0] sample_in,
    input  ser_cfg_t          cfg_q,
    input  logic [BW-1:0]     bidx,
    output logic              sdata_o
);

    localparam logic [BW-1:0] SHORT_OFS = BW'(FULL_W - SHORT_W);
    localparam logic [BW-1:0] TOP_IDX   = BW'(FULL_W - 1);

    logic [FULL_W-1:0] word_q;
    logic [BW-1:0]     idx;
    logic [BW-1:0]     lsb_base;

    always_comb begin
        lsb_base = (cfg_q.len == LEN_SHORT) ? SHORT_OFS : '0;
        idx      = cfg_q.lsb_first ? (lsb_base + bidx) : (TOP_IDX - bidx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wrap) begin
            word_q <= sample_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            sdata_o <= 1'b0;
        end else begin
            sdata_o <= word_q[idx];
        end
    end

    // R10: captured word held for the whole frame
    a_r10_word_held: assert property (@(posedge clk) disable iff (rst)
        (live && !wrap) |=> $stable(word_q));

endmodule

// File: rtl/ser_clock_gen.sv
module ser_clock_gen
    import ser_pkg::*;
#(
    parameter int FULL_W  = FULL_BITS,
    parameter int SHORT_W = SHORT_BITS,
    localparam int BW     = $clog2(FULL_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          live,
    input  ser_cfg_t      cfg_q,
    input  logic [BW-1:0] bidx,
    input  logic [1:0]    sub,
    input  logic [2:0]    ph6,
    output logic          dclk_o,
    output logic          fclk_o
);

    localparam logic [BW-1:0] HALF_FULL  = BW'(FULL_W / 2);
    localparam logic [BW-1:0] HALF_SHORT = BW'(SHORT_W / 2);
    localparam logic [2:0]    HALF_PER   = 3'(PH_STEPS / 2);

    logic [2:0]    lag;
    logic [BW-1:0] half_bits;
    logic          dclk_n;
    logic          fclk_n;

    always_comb begin
        lag       = (ph6 >= cfg_q.phase) ? (ph6 - cfg_q.phase)
                                         : (ph6 + 3'(PH_STEPS) - cfg_q.phase);
        dclk_n    = (lag < HALF_PER);
        half_bits = (cfg_q.len == LEN_SHORT) ? HALF_SHORT : HALF_FULL;
        fclk_n    = (bidx < half_bits);
    end

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            dclk_o <= 1'b0;
            fclk_o <= 1'b0;
        end else begin
            dclk_o <= dclk_n;
            fclk_o <= fclk_n;
        end
    end

    // R6: frame clock rises only on the first slot of a word
    a_r6_fclk_on_first: assert property (@(posedge clk) disable iff (rst)
        $rose(fclk_o) |-> ($past(bidx) == '0 && $past(sub) == 2'd0));

endmodule

// File: rtl/ser_word_serializer.sv
module ser_word_serializer
    import ser_pkg::*;
#(
    parameter int FULL_W  = FULL_BITS,
    parameter int SHORT_W = SHORT_BITS,
    localparam int BW     = $clog2(FULL_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FULL_W-1:0] sample_in,
    input  logic              cfg_short,
    input  logic              cfg_lsb_first,
    input  logic [2:0]        cfg_phase,
    output logic              ser_data,
    output logic              ser_dclk,
    output logic              ser_fclk
);

    ser_cfg_t      cfg_in;
    ser_cfg_t      cfg_q;
    logic          live;
    logic          wrap;
    logic [BW-1:0] bidx;
    logic [1:0]    sub;
    logic [2:0]    ph6;

    always_comb begin
        cfg_in.len       = cfg_short ? LEN_SHORT : LEN_FULL;
        cfg_in.lsb_first = cfg_lsb_first;
        cfg_in.phase     = cfg_phase;
    end

    ser_slot_timer #(.FULL_W(FULL_W), .SHORT_W(SHORT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .live   (live),
        .wrap   (wrap),
        .bidx   (bidx),
        .sub    (sub),
        .ph6    (ph6),
        .cfg_q  (cfg_q)
    );

    ser_bit_picker #(.FULL_W(FULL_W), .SHORT_W(SHORT_W)) u_picker (
        .clk       (clk),
        .rst       (rst),
        .live      (live),
        .wrap      (wrap),
        .sample_in (sample_in),
        .cfg_q     (cfg_q),
        .bidx      (bidx),
        .sdata_o   (ser_data)
    );

    ser_clock_gen #(.FULL_W(FULL_W), .SHORT_W(SHORT_W)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .live   (live),
        .cfg_q  (cfg_q),
        .bidx   (bidx),
        .sub    (sub),
        .ph6    (ph6),
        .dclk_o (ser_dclk),
        .fclk_o (ser_fclk)
    );

    // R1: reset silences every output on the next cycle
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!ser_data && !ser_dclk && !ser_fclk));

    // R3: MSB-first frame opens with the top bit of the captured sample
    a_r3_msb_lead: assert property (@(posedge clk) disable iff (rst)
        (wrap && !cfg_lsb_first) |=> ##1 (ser_data == $past(sample_in[FULL_W-1], 2)));

endmodule

// File: tb/ser_word_serializer_bench.sv
module ser_word_serializer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] sample_in = '0;
    logic        cfg_short = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [2:0]  cfg_phase = 3'd3;
    logic        ser_data, ser_dclk, ser_fclk;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    ser_word_serializer u_ser_word_serializer (
        .clk           (clk),
        .rst           (rst),
        .sample_in     (sample_in),
        .cfg_short     (cfg_short),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_phase     (cfg_phase),
        .ser_data      (ser_data),
        .ser_dclk      (ser_dclk),
        .ser_fclk      (ser_fclk)
    );

    // Behavioural reference model of the output stream
    bit          armed = 0;
    bit          m_live = 0;
    bit          m_first = 0;
    bit          m_lsb = 0;
    bit          m_mid = 0;
    bit          mid_flag = 0;
    int          m_t = 0;
    int          m_len = 12;
    int          m_ph = 3;
    int          m_raw = 3;
    logic [11:0] m_bits = '0;
    logic        e_d = 0, e_c = 0, e_f = 0;
    string       tag_d = "R1", tag_c = "R1", tag_f = "R1";

    always @(posedge clk) begin
        armed = 1;
        if (rst) begin
            e_d = 0; e_c = 0; e_f = 0;
            tag_d = "R1"; tag_c = "R1"; tag_f = "R1";
            m_live = 0;
        end else begin
            if (m_live) begin
                e_d = m_bits[m_t / 3];
                e_c = ((((m_t - m_ph) % 6) + 6) % 6) < 3;
                e_f = m_t < (m_len * 3) / 2;
                tag_d = m_first ? "R2" : (m_len == 10 ? "R5" : (m_lsb ? "R4" : "R3"));
                tag_d = {tag_d, " R10", (m_mid ? " R9" : "")};
                tag_c = (m_raw >= 6) ? "R8" : "R7";
                tag_f = m_first ? "R6 R2" : "R6";
            end else begin
                e_d = 0; e_c = 0; e_f = 0;
                tag_d = "R2"; tag_c = "R2"; tag_f = "R2";
            end
            if (!m_live || m_t == 3 * m_len - 1) begin
                m_first = !m_live;
                m_t   = 0;
                m_len = cfg_short ? 10 : 12;
                m_lsb = cfg_lsb_first;
                m_raw = int'(cfg_phase);
                m_ph  = m_raw % 6;
                m_mid = mid_flag;
                m_bits = '0;
                for (int i = 0; i < m_len; i++)
                    m_bits[i] = m_lsb ? sample_in[12 - m_len + i] : sample_in[11 - i];
            end else begin
                m_t++;
            end
            m_live = 1;
        end
    end

    task automatic check(input logic act, input logic exp, input string tag, input string name);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            check(ser_data, e_d, tag_d, "ser_data");
            check(ser_dclk, e_c, tag_c, "ser_dclk");
            check(ser_fclk, e_f, tag_f, "ser_fclk");
        end
    end

    // New sample every cycle so capture timing is exercised (R10)
    initial forever begin
        @(negedge clk);
        sample_in = 12'($urandom);
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R3: 12-bit MSB first, default phase
        repeat (150) @(negedge clk);
        // R4: 12-bit LSB first
        cfg_lsb_first = 1'b1;
        repeat (150) @(negedge clk);
        // R5: 10-bit MSB first
        cfg_short = 1'b1;
        cfg_lsb_first = 1'b0;
        repeat (130) @(negedge clk);
        // R4 and R5: 10-bit LSB first
        cfg_lsb_first = 1'b1;
        repeat (130) @(negedge clk);
        // R7 and R8: sweep every phase code in both lengths
        for (int p = 0; p < 8; p++) begin
            cfg_phase = 3'(p);
            cfg_short = p[0];
            repeat (80) @(negedge clk);
        end
        // R1 and R2: reset in mid-frame, then restart
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        // R9: configuration changes at arbitrary points inside frames
        mid_flag = 1'b1;
        for (int k = 0; k < 40; k++) begin
            cfg_short     = 1'($urandom);
            cfg_lsb_first = 1'($urandom);
            cfg_phase     = 3'($urandom);
            repeat (7) @(negedge clk);
        end
        mid_flag = 1'b0;
        repeat (80) @(negedge clk);
        finish_run();
    end

endmodule